// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. Each input feeds one bit of a pending-request vector. A per-input trigger selection decides how the input sets that bit: on a rising edge, or by following the input level. A mask vector hides requests. An in-service vector records the interrupts that the processor is handling.

Priority is relative to a three-bit rotation offset. The input at the offset has the highest priority, and priority falls off from there modulo eight. The block raises `intReq` only when the best visible request outranks every in-service interrupt that counts. `ackVec` always shows the input number that an acknowledge would return.

An acknowledge strobe commits the winner. End-of-interrupt, priority-set, mask-write and trigger-write commands arrive as decoded strobes. The surrounding bus logic and any cascading sit outside this block.

Top module: `rpi_core`

## Requirements
- R1: While `rstN` is low, the request, mask, in-service and offset registers and the stored input history are all zero, and `intReq` is low.
- R2: For an edge-mode input (trigger bit 0), the request bit is set on the clock edge where the input is high and its stored previous level is low. A falling input leaves the bit set, and a held-high input does not set it again.
- R3: For a level-mode input (trigger bit 1), the request bit takes the input value sampled at each clock edge.
- R4: The rank of input i is (i - offset) mod 8, and rank 0 is the best. An empty vector ranks 8. `intReq` is high exactly when the best rank of request AND NOT mask is strictly below the best rank of the in-service vector. A request that is equal in rank or lower does not signal.
- R5: `ackVec` gives the winning input number while `intReq` is high, and 7 otherwise. An acknowledge while `intReq` is low changes no register.
- R6: An acknowledge with auto-EOI off sets the winner's in-service bit. With auto-EOI and auto-rotate both on, it sets the offset to winner+1 mod 8 and leaves the in-service vector unchanged. With auto-EOI on and auto-rotate off, it changes neither.
- R7: An acknowledge clears the winner's request bit only for an edge-mode input.
- R8: With special-mask mode on, in-service bits that are masked take no part in the comparison of R4.
- R9: When parameter `IS_MASTER` is 1 and fully-nested mode is on, in-service bit `CASC_IN` (2 by default) takes no part in the comparison.
- R10: A trigger write stores `trigData` AND `TRIG_WMASK`. The write takes effect even during reset, and reset never clears the trigger register.
- R11: A non-specific EOI clears the best-ranked in-service bit. If `eoiRot` is set, the offset becomes the cleared input + 1 mod 8. With no in-service bit, the command does nothing.
- R12: A specific EOI clears in-service bit `eoiSel`, and with `eoiRot` it also sets the offset to `eoiSel`+1 mod 8. A priority write sets the offset to `prioSel`+1 mod 8.
- R13: Within one clock edge, input sampling is applied first, then the acknowledge, then the EOI. An acknowledged edge request is therefore cleared even if its input rises again on that edge. A non-specific EOI on the same edge can clear the in-service bit that the acknowledge has just set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Interrupt input lines |
| maskWr | input | 1 | Write strobe for the mask register |
| maskData | input | 8 | New mask value |
| trigWr | input | 1 | Write strobe for the trigger register |
| trigData | input | 8 | New trigger value (1 = level mode) |
| cfgSpecMask | input | 1 | Special-mask mode |
| cfgFullNest | input | 1 | Fully-nested mode (active only on the master variant) |
| cfgAutoEoi | input | 1 | Auto-EOI on acknowledge |
| cfgRotAeoi | input | 1 | Rotate the offset on an auto-EOI acknowledge |
| ackReq | input | 1 | Acknowledge strobe |
| eoiNonSpec | input | 1 | Non-specific EOI strobe |
| eoiSpec | input | 1 | Specific EOI strobe |
| eoiRot | input | 1 | Rotate the offset with the EOI |
| eoiSel | input | 3 | Target input of a specific EOI |
| prioWr | input | 1 | Priority-set strobe |
| prioSel | input | 3 | Input that takes the lowest priority |
| intReq | output | 1 | Interrupt request to the processor |
| ackVec | output | 3 | Winning input, or 7 if there is none |
| reqVec | output | 8 | Request register |
| maskVec | output | 8 | Mask register |
| svcVec | output | 8 | In-service register |
| prioOffset | output | 3 | Rotation offset |
| trigVec | output | 8 | Trigger register |

## Verification
The bench builds the master variant with its default trigger write mask of 0xF8. Because the master setting is on, fully-nested mode can show its effect of hiding in-service bit 2 from a pending input 3. The mask of 0xF8 lets the bench show that writing all ones keeps inputs 0 to 2 in edge mode while inputs 3 to 7 become level mode. The bench also sets the offset to several values, so that the winners and EOI targets differ from what a fixed-priority design would choose.

// File: rtl/rpi_pkg.sv
package rpi_pkg;
  localparam int N_IN   = 8;
  localparam int IDX_W  = $clog2(N_IN);
  localparam int RANK_W = IDX_W + 1;

  typedef logic [N_IN-1:0]   vec_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [RANK_W-1:0] rank_t;

  // control -> datapath commit strobes
  typedef struct packed {
    logic ackDo;
    idx_t ackId;
    logic ackSetSvc;
    logic ackRot;
    logic clrDo;
    idx_t clrId;
    logic clrRot;
    logic prioDo;
    idx_t prioId;
  } strobe_t;

  // best (smallest) rank present in v for rotation offset off; N_IN if empty
  function automatic rank_t bestRank(vec_t v, idx_t off);
    rank_t r;
    idx_t  pos;
    r = rank_t'(N_IN);
    for (int k = N_IN - 1; k >= 0; k--) begin
      pos = idx_t'(k) + off;
      if (v[pos]) r = rank_t'(k);
    end
    return r;
  endfunction

  function automatic idx_t rankToIdx(rank_t r, idx_t off);
    idx_t res;
    res = r[IDX_W-1:0] + off;
    return res;
  endfunction
endpackage

// File: rtl/rpi_ctrl.sv
module rpi_ctrl
  import rpi_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_IN   = 2
) (
  input  vec_t    reqVec,
  input  vec_t    maskVec,
  input  vec_t    svcVec,
  input  idx_t    prioOffset,
  input  logic    cfgSpecMask,
  input  logic    cfgFullNest,
  input  logic    cfgAutoEoi,
  input  logic    cfgRotAeoi,
  input  logic    ackReq,
  input  logic    eoiNonSpec,
  input  logic    eoiSpec,
  input  logic    eoiRot,
  input  idx_t    eoiSel,
  input  logic    prioWr,
  input  idx_t    prioSel,
  output logic    intReq,
  output idx_t    ackVec,
  output strobe_t strobes
);
  rank_t reqRank, svcRank, eoiRank;
  vec_t  svcView, svcPost;
  idx_t  winner, offPost;

  always_comb begin
    svcView = svcVec;
    if (cfgSpecMask) svcView = svcView & ~maskVec;
    if (IS_MASTER && cfgFullNest) svcView[CASC_IN] = 1'b0;
    reqRank = bestRank(reqVec & ~maskVec, prioOffset);
    svcRank = bestRank(svcView, prioOffset);
    intReq  = reqRank < svcRank;
    winner  = rankToIdx(reqRank, prioOffset);
    ackVec  = intReq ? winner : '1;
  end

  // view of state after the acknowledge, for the EOI search (sample -> ack -> EOI)
  always_comb begin
    strobes.ackDo     = ackReq & intReq;
    strobes.ackId     = winner;
    strobes.ackSetSvc = ~cfgAutoEoi;
    strobes.ackRot    = cfgAutoEoi & cfgRotAeoi;

    svcPost = svcVec;
    offPost = prioOffset;
    if (strobes.ackDo && !cfgAutoEoi) svcPost[winner] = 1'b1;
    if (strobes.ackDo && strobes.ackRot) offPost = winner + idx_t'(1);
    eoiRank = bestRank(svcPost, offPost);

    if (eoiNonSpec) begin
      strobes.clrDo = eoiRank != rank_t'(N_IN);
      strobes.clrId = rankToIdx(eoiRank, offPost);
    end else begin
      strobes.clrDo = eoiSpec;
      strobes.clrId = eoiSel;
    end
    strobes.clrRot = eoiRot & strobes.clrDo;
    strobes.prioDo = prioWr;
    strobes.prioId = prioSel;
  end
endmodule

// File: rtl/rpi_datapath.sv
module rpi_datapath
  import rpi_pkg::*;
#(
  parameter logic [N_IN-1:0] TRIG_WMASK = 8'hF8
) (
  input  logic    clk,
  input  logic    rstN,
  input  vec_t    irqIn,
  input  logic    maskWr,
  input  vec_t    maskData,
  input  logic    trigWr,
  input  vec_t    trigData,
  input  strobe_t strobes,
  output vec_t    reqVec,
  output vec_t    maskVec,
  output vec_t    svcVec,
  output idx_t    prioOffset,
  output vec_t    trigVec
);
  vec_t reqQ, maskQ, svcQ, prevQ;
  idx_t offQ;
  vec_t trigQ = '0;
  vec_t reqN, maskN, svcN;
  idx_t offN;

  always_comb begin
    // 1: sampling
    for (int i = 0; i < N_IN; i++) begin
      reqN[i] = trigQ[i] ? irqIn[i] : (reqQ[i] | (irqIn[i] & ~prevQ[i]));
    end
    svcN  = svcQ;
    offN  = offQ;
    maskN = maskWr ? maskData : maskQ;
    // 2: acknowledge
    if (strobes.ackDo) begin
      if (!trigQ[strobes.ackId]) reqN[strobes.ackId] = 1'b0;
      if (strobes.ackSetSvc)     svcN[strobes.ackId] = 1'b1;
      if (strobes.ackRot)        offN = strobes.ackId + idx_t'(1);
    end
    // 3: end of interrupt
    if (strobes.clrDo)  svcN[strobes.clrId] = 1'b0;
    if (strobes.clrRot) offN = strobes.clrId + idx_t'(1);
    if (strobes.prioDo) offN = strobes.prioId + idx_t'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ  <= '0;
      maskQ <= '0;
      svcQ  <= '0;
      prevQ <= '0;
      offQ  <= '0;
    end else begin
      reqQ  <= reqN;
      maskQ <= maskN;
      svcQ  <= svcN;
      prevQ <= irqIn;
      offQ  <= offN;
    end
  end

  // trigger selection survives reset
  always_ff @(posedge clk) begin
    if (trigWr) trigQ <= trigData & TRIG_WMASK;
  end

  assign reqVec     = reqQ;
  assign maskVec    = maskQ;
  assign svcVec     = svcQ;
  assign prioOffset = offQ;
  assign trigVec    = trigQ;
endmodule

// File: rtl/rpi_core.sv
module rpi_core #(
  parameter bit       IS_MASTER  = 1'b1,
  parameter int       CASC_IN    = 2,
  parameter bit [7:0] TRIG_WMASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqIn,
  input  logic       maskWr,
  input  logic [7:0] maskData,
  input  logic       trigWr,
  input  logic [7:0] trigData,
  input  logic       cfgSpecMask,
  input  logic       cfgFullNest,
  input  logic       cfgAutoEoi,
  input  logic       cfgRotAeoi,
  input  logic       ackReq,
  input  logic       eoiNonSpec,
  input  logic       eoiSpec,
  input  logic       eoiRot,
  input  logic [2:0] eoiSel,
  input  logic       prioWr,
  input  logic [2:0] prioSel,
  output logic       intReq,
  output logic [2:0] ackVec,
  output logic [7:0] reqVec,
  output logic [7:0] maskVec,
  output logic [7:0] svcVec,
  output logic [2:0] prioOffset,
  output logic [7:0] trigVec
);
  rpi_pkg::strobe_t strobes;

  rpi_ctrl #(.IS_MASTER(IS_MASTER), .CASC_IN(CASC_IN)) uCtrl (
    .reqVec(reqVec), .maskVec(maskVec), .svcVec(svcVec), .prioOffset(prioOffset),
    .cfgSpecMask(cfgSpecMask), .cfgFullNest(cfgFullNest),
    .cfgAutoEoi(cfgAutoEoi), .cfgRotAeoi(cfgRotAeoi),
    .ackReq(ackReq), .eoiNonSpec(eoiNonSpec), .eoiSpec(eoiSpec),
    .eoiRot(eoiRot), .eoiSel(eoiSel), .prioWr(prioWr), .prioSel(prioSel),
    .intReq(intReq), .ackVec(ackVec), .strobes(strobes)
  );

  rpi_datapath #(.TRIG_WMASK(TRIG_WMASK)) uData (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .maskWr(maskWr), .maskData(maskData), .trigWr(trigWr), .trigData(trigData),
    .strobes(strobes),
    .reqVec(reqVec), .maskVec(maskVec), .svcVec(svcVec),
    .prioOffset(prioOffset), .trigVec(trigVec)
  );
endmodule

// File: rtl/rpi_core_chk.sv
module rpi_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] irqIn,
  input logic       trigWr,
  input logic       cfgAutoEoi,
  input logic       ackReq,
  input logic       eoiNonSpec,
  input logic       eoiSpec,
  input logic       intReq,
  input logic [2:0] ackVec,
  input logic [7:0] reqVec,
  input logic [7:0] maskVec,
  input logic [7:0] svcVec,
  input logic [7:0] trigVec
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !intReq);

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((reqVec & $past(trigVec)) == ($past(irqIn) & $past(trigVec))));

  p_int_needs_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((reqVec & ~maskVec) != 8'h00));

  p_spurious_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    !intReq |-> (ackVec == 3'd7));

  p_ack_sets_svc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && intReq && !cfgAutoEoi && !eoiNonSpec && !eoiSpec) |=> svcVec[$past(ackVec)]);

  p_edge_ack_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && intReq && !trigVec[ackVec]) |=> !reqVec[$past(ackVec)]);

  p_trig_kept_r10: assert property (@(posedge clk)
    (!rstN && !trigWr) |=> $stable(trigVec));
endmodule

bind rpi_core rpi_core_chk uChk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .trigWr(trigWr),
  .cfgAutoEoi(cfgAutoEoi), .ackReq(ackReq), .eoiNonSpec(eoiNonSpec),
  .eoiSpec(eoiSpec), .intReq(intReq), .ackVec(ackVec), .reqVec(reqVec),
  .maskVec(maskVec), .svcVec(svcVec), .trigVec(trigVec)
);

// File: tb/rpi_core_test.sv
module rpi_core_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqIn = '0, maskData = '0, trigData = '0;
  logic maskWr = 0, trigWr = 0, cfgSpecMask = 0, cfgFullNest = 0;
  logic cfgAutoEoi = 0, cfgRotAeoi = 0, ackReq = 0;
  logic eoiNonSpec = 0, eoiSpec = 0, eoiRot = 0, prioWr = 0;
  logic [2:0] eoiSel = '0, prioSel = '0;
  logic intReq;
  logic [2:0] ackVec, prioOffset;
  logic [7:0] reqVec, maskVec, svcVec, trigVec;
  int nChecks = 0, nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpi_core uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .maskWr(maskWr), .maskData(maskData),
    .trigWr(trigWr), .trigData(trigData), .cfgSpecMask(cfgSpecMask),
    .cfgFullNest(cfgFullNest), .cfgAutoEoi(cfgAutoEoi), .cfgRotAeoi(cfgRotAeoi),
    .ackReq(ackReq), .eoiNonSpec(eoiNonSpec), .eoiSpec(eoiSpec), .eoiRot(eoiRot),
    .eoiSel(eoiSel), .prioWr(prioWr), .prioSel(prioSel), .intReq(intReq),
    .ackVec(ackVec), .reqVec(reqVec), .maskVec(maskVec), .svcVec(svcVec),
    .prioOffset(prioOffset), .trigVec(trigVec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // single-cycle strobes cleared after the edge
  task automatic clearStrobes();
    ackReq = 0; eoiNonSpec = 0; eoiSpec = 0; eoiRot = 0;
    prioWr = 0; maskWr = 0; trigWr = 0;
  endtask

  task automatic t_reset();
    rstN = 0; trigWr = 1; trigData = 8'hFF;
    tick(); tick();
    trigWr = 0;
    chk("R10 masked trig write in reset", trigVec, 8'hF8);
    chk("R1 int low in reset", intReq, 0);
    rstN = 1;
    tick();
    chk("R1 req zero", reqVec, 0);
    chk("R1 svc zero", svcVec, 0);
    chk("R1 mask zero", maskVec, 0);
    chk("R1 offset zero", prioOffset, 0);
    trigWr = 1; trigData = 8'h00; tick(); clearStrobes();
    chk("R10 trig all edge", trigVec, 0);
  endtask

  task automatic t_edge();
    irqIn = 8'h01; tick();
    chk("R2 rising sets", reqVec, 8'h01);
    chk("R5 winner 0", ackVec, 0);
    irqIn = 8'h00; tick();
    chk("R2 falling keeps", reqVec, 8'h01);
    ackReq = 1; tick(); clearStrobes();
    chk("R7 edge ack clears", reqVec, 8'h00);
    chk("R6 ack sets svc", svcVec, 8'h01);
    irqIn = 8'h01; tick();
    chk("R2 new rise", reqVec, 8'h01);
    chk("R4 equal rank blocked", intReq, 0);
    eoiNonSpec = 1; tick(); clearStrobes();
    chk("R11 eoi clears", svcVec, 8'h00);
    chk("R4 int after eoi", intReq, 1);
    ackReq = 1; tick(); clearStrobes();
    tick();
    chk("R2 held high no reset", reqVec, 8'h00);
    eoiNonSpec = 1; tick(); clearStrobes();
    chk("R11 eoi clears again", svcVec, 8'h00);
    irqIn = 8'h00; tick();
  endtask

  task automatic t_rank();
    irqIn = 8'h0C; tick();
    chk("R4 winner 2", ackVec, 2);
    ackReq = 1; tick(); clearStrobes();
    chk("R6 svc bit2", svcVec, 8'h04);
    chk("R4 lower rank blocked", intReq, 0);
    chk("R5 spurious code", ackVec, 7);
    ackReq = 1; tick(); clearStrobes();
    chk("R5 spurious ack req", reqVec, 8'h08);
    chk("R5 spurious ack svc", svcVec, 8'h04);
    irqIn = 8'h0E; tick();
    chk("R4 higher preempts", {intReq, ackVec}, {1'b1, 3'd1});
    maskWr = 1; maskData = 8'h02; tick(); clearStrobes();
    chk("R4 masked request", intReq, 0);
    cfgSpecMask = 1; maskWr = 1; maskData = 8'h06; tick(); clearStrobes();
    chk("R8 special mask", {intReq, ackVec}, {1'b1, 3'd3});
    cfgSpecMask = 0; maskWr = 1; maskData = 8'h02; tick(); clearStrobes();
    chk("R8 special mask off", intReq, 0);
    cfgFullNest = 1; tick();
    chk("R9 fully nested", {intReq, ackVec}, {1'b1, 3'd3});
    cfgFullNest = 0;
    eoiSpec = 1; eoiSel = 3'd2; tick(); clearStrobes();
    chk("R12 specific eoi", svcVec, 8'h00);
    maskWr = 1; maskData = 8'h00; tick(); clearStrobes();
    chk("R4 winner 1", ackVec, 1);
  endtask

  task automatic t_rotate();
    prioWr = 1; prioSel = 3'd4; tick(); clearStrobes();
    chk("R12 prio set", prioOffset, 5);
    chk("R4 rotated winner", ackVec, 1);
    ackReq = 1; tick(); clearStrobes();
    chk("R6 svc bit1", svcVec, 8'h02);
    irqIn = 8'h4E; tick();
    chk("R4 rotated preempt", {intReq, ackVec}, {1'b1, 3'd6});
    ackReq = 1; tick(); clearStrobes();
    chk("R6 svc two", svcVec, 8'h42);
    eoiNonSpec = 1; tick(); clearStrobes();
    chk("R11 best-ranked cleared", svcVec, 8'h02);
    eoiNonSpec = 1; eoiRot = 1; tick(); clearStrobes();
    chk("R11 rotating eoi svc", svcVec, 8'h00);
    chk("R11 rotating eoi offset", prioOffset, 2);
    chk("R4 winner 3", ackVec, 3);
    eoiSpec = 1; eoiRot = 1; eoiSel = 3'd5; tick(); clearStrobes();
    chk("R12 specific rotate", prioOffset, 6);
  endtask

  task automatic t_aeoi();
    cfgAutoEoi = 1; cfgRotAeoi = 1;
    ackReq = 1; tick(); clearStrobes();
    chk("R6 aeoi svc", svcVec, 8'h00);
    chk("R6 aeoi rotate", prioOffset, 4);
    chk("R7 edge cleared", reqVec, 8'h00);
    cfgRotAeoi = 0; irqIn = 8'h4F; tick();
    chk("R4 winner 0", ackVec, 0);
    ackReq = 1; tick(); clearStrobes();
    chk("R6 aeoi no rotate", {svcVec, 5'd0, prioOffset}, {8'h00, 5'd0, 3'd4});
    cfgAutoEoi = 0;
  endtask

  task automatic t_level();
    irqIn = 8'h00; trigWr = 1; trigData = 8'hFF; tick(); clearStrobes();
    chk("R10 trig F8", trigVec, 8'hF8);
    irqIn = 8'h10; tick();
    chk("R3 level high", reqVec, 8'h10);
    chk("R4 level winner", ackVec, 4);
    ackReq = 1; tick(); clearStrobes();
    chk("R7 level kept", reqVec, 8'h10);
    irqIn = 8'h00; tick();
    chk("R3 level low", reqVec, 8'h00);
    eoiNonSpec = 1; tick(); clearStrobes();
  endtask

  task automatic t_order();
    irqIn = 8'h01; tick();
    chk("R13 setup", ackVec, 0);
    ackReq = 1; eoiNonSpec = 1; tick(); clearStrobes();
    chk("R13 ack then eoi", {reqVec, svcVec}, 16'h0000);
    irqIn = 8'h00; tick();
    irqIn = 8'h01; tick();
    irqIn = 8'h00; tick();
    irqIn = 8'h01; ackReq = 1; tick(); clearStrobes();
    chk("R13 sample then ack req", reqVec, 8'h00);
    chk("R13 sample then ack svc", svcVec, 8'h01);
    eoiNonSpec = 1; irqIn = 8'h00; tick(); clearStrobes();
  endtask

  task automatic t_reset_keep();
    maskWr = 1; maskData = 8'hAA; tick(); clearStrobes();
    rstN = 0; tick();
    chk("R1 mask cleared", maskVec, 8'h00);
    chk("R1 offset cleared", prioOffset, 0);
    chk("R10 trig survives reset", trigVec, 8'hF8);
    rstN = 1; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_edge();
    t_rank();
    t_rotate();
    t_aeoi();
    t_level();
    t_order();
    t_reset_keep();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule